// File: doc/BRIEF.md
# Serial Configuration Loader with Chain Pass-Through

This block is the receiving end of a serial configuration link. An outside source drives the configuration clock and presents one bitstream bit on `din` ahead of every rising edge. The block stays idle until the mode pins select slave serial operation and the shared readiness line reads high. It then collects its own image as 32-bit words and closes the image with a CRC-32 comparison against one trailing check word.

On a good check the block raises `done` and becomes a one-stage serial repeater. Each bit sampled on a rising edge leaves on `dout` after that same edge, so the next device in a chain can be fed from this one. Repeating stops after a fixed number of 32-bit words, and `dout` then idles high. On a bad check it raises `crc_err` and holds the readiness line low until a synchronous reset.

The serial path has no valid/ready handshake and no back-pressure. Every rising edge consumes the bit on `din`, and the source alone sets the pace by gating its clock. The control and status pins are plain levels.

Top module: `cfgld_top`

## Requirements
- R1: A synchronous reset (`rst` high on a rising edge) returns the block to waiting and clears the bit, word and forward counters and the CRC. After that edge `done`, `crc_err` and `ready_pull_low` read 0 and `dout` reads 1.
- R2: Loading can start only when `mode[2]` and `mode[1]` are both 1. `mode[0]` is ignored, and so is any change of `mode` once loading has begun.
- R3: While waiting, no bit is taken. The edge at which `ready_in` is first seen high (with a valid mode) only arms the block, and the first image bit is sampled on the next rising edge.
- R4: Image bits enter most significant bit first and form 32-bit words. The image is `img_len` data words followed by one check word. `img_len` must be held stable while loading.
- R5: The check value is a CRC-32 over the data words only. It uses polynomial 0x04C11DB7, starts from all ones, feeds each word most significant bit first, and applies no bit reflection and no final inversion.
- R6: When the check word equals the CRC, `done` reads 1 after the edge that samples the last check bit. It stays 1 until reset, with `crc_err` at 0.
- R7: When the check word differs, `crc_err` and `ready_pull_low` read 1 after that same edge. Both stay 1 until reset, `done` stays 0, and no later bit is forwarded.
- R8: Whenever the block was not in pass-through mode at a rising edge, `dout` reads 1 after that edge.
- R9: In pass-through mode, `dout` after each rising edge equals the `din` bit sampled on that edge.
- R10: At most `FWD_LIMIT_WORDS`×32 bits are forwarded (default 1,048,575 words). After the limit, `dout` reads 1 for good.
- R11: With `img_len` = 0 the first word is the check word, and it is compared against the seed value 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Externally driven configuration clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Mode pins; slave serial when bits 2 and 1 are 1, reset value all ones |
| ready_in | input | 1 | Level of the shared open-drain readiness line |
| din | input | 1 | Serial bitstream input |
| img_len | input | LEN_W | Number of data words in this block's own image |
| dout | output | 1 | Serial output to the next device; 1 when not repeating |
| done | output | 1 | Own image loaded with a matching CRC |
| crc_err | output | 1 | Own image failed its CRC check |
| ready_pull_low | output | 1 | 1 requests the readiness line to be driven low |

## Verification
A three-word image with a correct check word is loaded after garbage zeros that arrive while readiness is low. This separates a correct start point and bit order from an off-by-one start or a reversed shift. The same run then streams an irregular pattern through the repeater past its limit, which shows the one-edge forwarding path and the exact cut-off word count. A corrupted check word, a zero-length image and a start held back by an invalid mode (with a mode change during loading) tell apart the fail path, the seed comparison and mode gating.

// File: rtl/cfgld_pkg.sv
`timescale 1ns/1ps
package cfgld_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_LOAD = 2'd1,
    ST_PASS = 2'd2,
    ST_FAIL = 2'd3
  } ld_state_e;

  // Advance a CRC register over one word, most significant bit first.
  function automatic logic [WORD_W-1:0] crc_step(input logic [WORD_W-1:0] cur,
                                                 input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    logic fb;
    r = cur;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = r[WORD_W-1] ^ w[i];
      r  = {r[WORD_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/cfgld_shifter.sv
`timescale 1ns/1ps
module cfgld_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         word_done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-2:0]  sreg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (en) begin
      sreg <= {sreg[W-3:0], din};
      cnt  <= (cnt == LAST) ? '0 : cnt + CW'(1);
    end
  end

  assign word      = {sreg, din};
  assign word_done = en && (cnt == LAST);
endmodule

// File: rtl/cfgld_crc.sv
`timescale 1ns/1ps
module cfgld_crc
  import cfgld_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (rst)      crc <= CRC_SEED;
    else if (upd) crc <= crc_step(crc, word);
  end
endmodule

// File: rtl/cfgld_fwd.sv
`timescale 1ns/1ps
module cfgld_fwd #(
  parameter int LIMIT_WORDS = 1048575,
  parameter int W           = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic din,
  output logic dout
);
  localparam longint LIMIT_BITS = longint'(LIMIT_WORDS) * longint'(W);
  localparam int     CW         = $clog2(LIMIT_BITS + 1);

  logic [CW-1:0] sent;
  logic          room;

  assign room = (sent != CW'(LIMIT_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b1;
      sent <= '0;
    end else if (active && room) begin
      dout <= din;
      sent <= sent + CW'(1);
    end else begin
      dout <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgld_top.sv
`timescale 1ns/1ps
module cfgld_top
  import cfgld_pkg::*;
#(
  parameter int LEN_W           = 20,
  parameter int FWD_LIMIT_WORDS = 1048575
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic             ready_in,
  input  logic             din,
  input  logic [LEN_W-1:0] img_len,
  output logic             dout,
  output logic             done,
  output logic             crc_err,
  output logic             ready_pull_low
);
  ld_state_e         state_q, state_d;
  logic [LEN_W-1:0]  word_cnt;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] crc_q;
  logic              word_done;
  logic              is_check;
  logic              mode_ok;
  logic              unused_mode0;

  assign unused_mode0 = mode[0];
  assign mode_ok      = mode[2] & mode[1];
  assign is_check     = (word_cnt == img_len);

  cfgld_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .en(state_q == ST_LOAD), .din(din),
    .word(word), .word_done(word_done)
  );

  cfgld_crc u_crc (
    .clk(clk), .rst(rst), .upd(word_done && !is_check),
    .word(word), .crc(crc_q)
  );

  cfgld_fwd #(.LIMIT_WORDS(FWD_LIMIT_WORDS), .W(WORD_W)) u_fwd (
    .clk(clk), .rst(rst), .active(state_q == ST_PASS), .din(din), .dout(dout)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT: if (mode_ok && ready_in) state_d = ST_LOAD;
      ST_LOAD: if (word_done && is_check) state_d = (word == crc_q) ? ST_PASS : ST_FAIL;
      ST_PASS: state_d = ST_PASS;
      ST_FAIL: state_d = ST_FAIL;
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_WAIT;
      word_cnt <= '0;
    end else begin
      state_q <= state_d;
      if (word_done && !is_check) word_cnt <= word_cnt + LEN_W'(1);
    end
  end

  assign done           = (state_q == ST_PASS);
  assign crc_err        = (state_q == ST_FAIL);
  assign ready_pull_low = (state_q == ST_FAIL);
endmodule

// File: rtl/cfgld_chk.sv
`timescale 1ns/1ps
module cfgld_chk
  import cfgld_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       ready_in,
  input logic [1:0] mode_hi,
  input logic       dout,
  input logic       done,
  input logic       crc_err,
  input logic       ready_pull_low,
  input ld_state_e  state_q
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (state_q == ST_WAIT && !done && !crc_err && !ready_pull_low && dout)); // R1

  AST_HOLD_UNTIL_GO: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !(ready_in && mode_hi == 2'b11)) |=> state_q == ST_WAIT); // R3

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !crc_err)); // R6

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    crc_err |=> (crc_err && ready_pull_low && !done)); // R7

  AST_DOUT_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !done |=> dout); // R8
endmodule

bind cfgld_top cfgld_chk u_chk (
  .clk(clk), .rst(rst), .ready_in(ready_in), .mode_hi(mode[2:1]),
  .dout(dout), .done(done), .crc_err(crc_err),
  .ready_pull_low(ready_pull_low), .state_q(state_q)
);

// File: tb/cfgld_top_tb.sv
`timescale 1ns/1ps
module cfgld_top_tb;
  localparam int LIM = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode = 3'b111;
  logic        ready_in = 1'b0;
  logic        din = 1'b1;
  logic [19:0] img_len = '0;
  logic        dout, done, crc_err, ready_pull_low;

  int checks = 0;
  int errors = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  cfgld_top #(.LEN_W(20), .FWD_LIMIT_WORDS(LIM)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .ready_in(ready_in), .din(din),
    .img_len(img_len), .dout(dout), .done(done), .crc_err(crc_err),
    .ready_pull_low(ready_pull_low)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: after each rising edge, pop the expected serial output.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dout === e, t, {31'd0, dout}, {31'd0, e});
      end
    end
  end

  // Driver: present one bit and queue the output expected after the edge.
  task automatic send_bit(input logic b, input logic e, input string tag);
    @(negedge clk);
    din = b;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic send_word(input logic [31:0] w, input string tag);
    for (int i = 31; i >= 0; i--) send_bit(w[i], 1'b1, tag);
  endtask

  task automatic flags(input logic d, input logic er, input string tag);
    @(posedge clk);
    #1;
    check(done === d, tag, {31'd0, done}, {31'd0, d});
    check(crc_err === er, tag, {31'd0, crc_err}, {31'd0, er});
    check(ready_pull_low === er, tag, {31'd0, ready_pull_low}, {31'd0, er});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ready_in = 1'b0; mode = 3'b111; din = 1'b0;
    exp_q.push_back(1'b1); tag_q.push_back("R1");
    @(negedge clk);
    rst = 1'b0;
    exp_q.push_back(1'b1); tag_q.push_back("R1");
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] ws[4], input int n);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 31; i >= 0; i--) begin
        fb = c[31] ^ ws[k][i];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    return c;
  endfunction

  // Arm (one non-loaded bit with ready high), then the words and check word.
  task automatic load_image(input logic [31:0] ws[4], input int n, input bit corrupt, input string tag);
    logic [31:0] c;
    c = ref_crc(ws, n) ^ (corrupt ? 32'h0000_0100 : 32'h0);
    img_len = 20'(n);
    @(negedge clk);
    ready_in = 1'b1; din = 1'b1;
    exp_q.push_back(1'b1); tag_q.push_back("R3");
    for (int k = 0; k < n; k++) send_word(ws[k], tag);
    send_word(c, tag);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired, run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ws[4];
    int fwd;

    // R1: reset state
    do_reset();
    flags(1'b0, 1'b0, "R1");

    // R3: bits while readiness is low are ignored
    for (int i = 0; i < 7; i++) send_bit(1'b0, 1'b1, "R3");
    ws[0] = 32'h8000_0001; ws[1] = 32'hDEAD_BEEF; ws[2] = 32'h1234_5678; ws[3] = 32'h0;
    load_image(ws, 3, 1'b0, "R8");
    flags(1'b1, 1'b0, "R4 R5 R6");

    // R9 and R10: repeat with cut-off after LIM words
    fwd = 0;
    for (int i = 0; i < LIM * 32 + 8; i++) begin
      logic b;
      b = ((i * 7) % 5) < 2;
      if (fwd < LIM * 32) send_bit(b, b, "R9");
      else send_bit(b, 1'b1, "R10");
      fwd++;
    end
    flags(1'b1, 1'b0, "R6");

    // R7: corrupted check word
    do_reset();
    ws[0] = 32'hCAFE_F00D; ws[1] = 32'h0F0F_0F0F;
    load_image(ws, 2, 1'b1, "R8");
    flags(1'b0, 1'b1, "R7");
    for (int i = 0; i < 12; i++) send_bit(i[0], 1'b1, "R7");
    flags(1'b0, 1'b1, "R7");

    // R11: zero-length image, check word equals the seed
    do_reset();
    load_image(ws, 0, 1'b0, "R11");
    flags(1'b1, 1'b0, "R11");

    // R2: invalid mode holds off; mode[0] and later mode changes ignored
    do_reset();
    @(negedge clk);
    mode = 3'b010; ready_in = 1'b1; din = 1'b0;
    exp_q.push_back(1'b1); tag_q.push_back("R2");
    for (int i = 0; i < 9; i++) send_bit(1'b0, 1'b1, "R2");
    flags(1'b0, 1'b0, "R2");
    mode = 3'b110;
    ws[0] = 32'h5A5A_00FF;
    img_len = 20'd1;
    @(negedge clk);
    din = 1'b1;
    exp_q.push_back(1'b1); tag_q.push_back("R2");
    for (int i = 31; i >= 0; i--) begin
      send_bit(ws[0][i], 1'b1, "R2");
      if (i == 20) mode = 3'b001;
    end
    send_word(ref_crc(ws, 1), "R2");
    flags(1'b1, 1'b0, "R2");

    repeat (3) @(posedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule